// File: doc/BRIEF.md
# Prioritized Interrupt Status Register

This block gathers six interrupt request lines, masks each one with its own enable, and sums them into one interrupt output. Software reads a status register that reports the highest-priority pending, enabled source as a level index and a pending flag. Each request line is built either as an event source or as a level source, chosen by a parameter. An event source is caught in a sticky latch. A level source is pending for as long as its line stays high.

A read strobe freezes the reported code for the length of the strobe. When the strobe ends, only the source that was reported is acknowledged. Any other source that is still pending, at a higher or lower priority, is reported on the next read. Software drains several pending sources by reading the register again until the pending flag shows idle.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, irq_o is 0 and rd_data_o reads 8'h01 (no pending source).
- R2: A one-cycle pulse on an enabled event source is latched. irq_o rises in the following cycle and stays high until that source is acknowledged.
- R3: Level 0 has the highest priority and level 5 the lowest. rd_data_o bits [3:1] carry the index of the highest-priority pending enabled source. Bit 0 is 0 when a source is pending and 1 when none is, with bits [3:1] reading 0 in that case. Bits [7:4] always read 0.
- R4: A source whose enable bit is 0 is neither reported nor counted in irq_o. An event it latched is kept, and it is reported once its enable is set again.
- R5: The code is captured in the first cycle of the read strobe. rd_data_o holds that value for the rest of the strobe, even if a higher-priority source becomes pending during the read.
- R6: When the strobe falls, only the captured source is cleared. All other pending sources remain, and the next read reports the next one in priority order.
- R7: An event arriving on a source in the same cycle as that source's clear wins, and the source stays pending.
- R8: A level source (EVENT_MASK bit 0; by default source 2) follows its input line. A read does not clear it, and it stops pending only when its line falls.
- R9: A read while nothing is pending returns 8'h01 and clears nothing.
- R10: irq_o is high exactly when at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 6 | Interrupt request lines, bit n is level n |
| en_i | input | 6 | Per-source enables |
| rd_i | input | 1 | Status read strobe, may last several cycles |
| rd_data_o | output | 8 | Status code: bit 0 idle flag, bits 3:1 level index |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a clear and a new event meeting on the same source in the same clock cycle. The bench drops the read strobe and raises that source's line on the same falling edge, then checks that the source still reads as pending afterwards. A second hard case is a higher-priority event arriving in the middle of a multi-cycle strobe. The bench pulses level 0 one cycle after the strobe has risen on level 5, then checks that the data stays frozen, that only level 5 is cleared, and that level 0 is reported on the next read.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned NUM_SRC_DEF = 6;
  localparam int unsigned DW_DEF      = 8;

  // one-hot vector for a level index
  function automatic logic [NUM_SRC_DEF-1:0] lvl_onehot(input logic [2:0] lvl);
    logic [NUM_SRC_DEF-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SRC_DEF; i++)
      if (lvl == 3'(i)) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter bit IS_EVENT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  if (IS_EVENT) begin : g_event
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (req_i)    q <= 1'b1;  // new event beats clear
      else if (clr_i)    q <= 1'b0;
    end
    assign pend_o = q;
  end else begin : g_level
    logic unused_clr;
    assign unused_clr = clr_i;
    assign pend_o = req_i;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [NUM_SRC-1:0] act_i,
  output logic [LVL_W-1:0]   lvl_o,
  output logic               none_o
);
  always_comb begin
    lvl_o  = '0;
    none_o = 1'b1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        lvl_o  = LVL_W'(i);
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_rd_ctrl.sv
module irq_rd_ctrl #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned LVL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               none_i,
  output logic               rd_q_o,
  output logic [LVL_W-1:0]   cap_lvl_o,
  output logic               cap_none_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic             rd_q;
  logic [LVL_W-1:0] cap_lvl;
  logic             cap_none;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      cap_lvl  <= '0;
      cap_none <= 1'b1;
    end else begin
      rd_q <= rd_i;
      if (rd_i && !rd_q) begin
        cap_lvl  <= lvl_i;
        cap_none <= none_i;
      end
    end
  end

  always_comb begin
    clr_o = '0;
    if (rd_q && !rd_i && !cap_none)
      for (int i = 0; i < NUM_SRC; i++)
        if (cap_lvl == LVL_W'(i)) clr_o[i] = 1'b1;
  end

  assign rd_q_o     = rd_q;
  assign cap_lvl_o  = cap_lvl;
  assign cap_none_o = cap_none;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned     NUM_SRC    = irq_status_pkg::NUM_SRC_DEF,
  parameter int unsigned     DW         = irq_status_pkg::DW_DEF,
  parameter logic [NUM_SRC-1:0] EVENT_MASK = 6'b111011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               rd_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               irq_o
);
  localparam int unsigned LVL_W = $clog2(NUM_SRC);
  localparam int unsigned PAD_W = DW - LVL_W - 1;

  logic [NUM_SRC-1:0] pend, act, clr;
  logic [LVL_W-1:0]   lvl, cap_lvl;
  logic               none, cap_none, rd_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_latch #(.IS_EVENT(EVENT_MASK[g])) i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (src_i[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  assign act = pend & en_i;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_enc (
    .act_i  (act),
    .lvl_o  (lvl),
    .none_o (none)
  );

  irq_rd_ctrl #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .lvl_i      (lvl),
    .none_i     (none),
    .rd_q_o     (rd_q),
    .cap_lvl_o  (cap_lvl),
    .cap_none_o (cap_none),
    .clr_o      (clr)
  );

  // frozen code while strobe is held
  assign rd_data_o = rd_q ? {{PAD_W{1'b0}}, cap_lvl, cap_none}
                          : {{PAD_W{1'b0}}, lvl, none};
  assign irq_o     = |act;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned        NUM_SRC    = 6,
  parameter int unsigned        DW         = 8,
  parameter logic [NUM_SRC-1:0] EVENT_MASK = '1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               rd_i,
  input logic [DW-1:0]      rd_data_o,
  input logic               irq_o,
  input logic               rd_q,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] clr
);
  // R3
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[DW-1:4] == '0) && (rd_data_o[0] || rd_data_o[3:1] < 3'(NUM_SRC)));

  // R10
  irq_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |-> (irq_o == !rd_data_o[0]));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && rd_i) |=> $stable(rd_data_o));

  // R6
  single_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));

  // R6
  clr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr != '0) |-> (rd_q && !rd_i));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    if (EVENT_MASK[g]) begin : g_ev
      // R7
      event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[g] |=> pend[g]);
      // R6
      keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend[g] && !clr[g]) |=> pend[g]);
    end
  end

  logic unused_en;
  assign unused_en = ^en_i;
endmodule

bind irq_status_reg irq_status_chk #(
  .NUM_SRC(NUM_SRC), .DW(DW), .EVENT_MASK(EVENT_MASK)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .en_i(en_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .rd_q(rd_q), .pend(pend), .clr(clr)
);

// File: tb/test_irq_status_reg.sv
module test_irq_status_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] src_i = '0;
  logic [5:0] en_i = '1;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;
  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  irq_status_reg i_irq_status_reg (
    .clk_i, .rst_ni, .src_i, .en_i, .rd_i, .rd_data_o, .irq_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int idx);
    src_i[idx] = 1'b1;
    @(negedge clk_i);
    src_i[idx] = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_i = 1'b1;
    @(negedge clk_i);
    v = rd_data_o;
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 irq", 8'(irq_o), 8'h00);
    chk("R1 data", rd_data_o, 8'h01);
  endtask

  task automatic t_single();
    logic [7:0] v;
    pulse(3);
    chk("R2 irq set", 8'(irq_o), 8'h01);
    repeat (5) @(negedge clk_i);
    chk("R2 irq held", 8'(irq_o), 8'h01);
    do_read(v);
    chk("R3 code lvl3", v, 8'h06);
    chk("R10 irq idle", 8'(irq_o), 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    src_i = 6'b110010;
    @(negedge clk_i);
    src_i = '0;
    do_read(v); chk("R3 first lvl1", v, 8'h02);
    do_read(v); chk("R6 next lvl4", v, 8'h08);
    do_read(v); chk("R6 next lvl5", v, 8'h0A);
    do_read(v); chk("R9 empty", v, 8'h01);
    chk("R10 irq idle", 8'(irq_o), 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    en_i = 6'b111110;
    pulse(0);
    chk("R4 masked irq", 8'(irq_o), 8'h00);
    chk("R4 masked data", rd_data_o, 8'h01);
    en_i = '1;
    #1;
    chk("R4 unmasked irq", 8'(irq_o), 8'h01);
    chk("R4 unmasked data", rd_data_o, 8'h00);
    do_read(v);
    chk("R4 read lvl0", v, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    pulse(5);
    rd_i = 1'b1;
    @(negedge clk_i);
    src_i[0] = 1'b1;
    @(negedge clk_i);
    src_i[0] = 1'b0;
    chk("R5 frozen", rd_data_o, 8'h0A);
    @(negedge clk_i);
    chk("R5 still frozen", rd_data_o, 8'h0A);
    rd_i = 1'b0;
    @(negedge clk_i);
    chk("R6 lvl0 left", rd_data_o, 8'h00);
    chk("R10 irq", 8'(irq_o), 8'h01);
    do_read(v);
    chk("R6 lvl0 read", v, 8'h00);
    chk("R6 lvl5 gone", rd_data_o, 8'h01);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    pulse(3);
    rd_i = 1'b1;
    @(negedge clk_i);
    chk("R7 captured", rd_data_o, 8'h06);
    rd_i = 1'b0;
    src_i[3] = 1'b1;
    @(negedge clk_i);
    src_i[3] = 1'b0;
    chk("R7 still pending", rd_data_o, 8'h06);
    do_read(v);
    chk("R7 read", v, 8'h06);
    chk("R7 cleared", rd_data_o, 8'h01);
  endtask

  task automatic t_level();
    logic [7:0] v;
    src_i[2] = 1'b1;
    @(negedge clk_i);
    pulse(4);
    do_read(v);
    chk("R8 lvl2 read", v, 8'h04);
    chk("R8 not cleared", rd_data_o, 8'h04);
    src_i[2] = 1'b0;
    #1;
    chk("R8 follows line", rd_data_o, 8'h08);
    do_read(v);
    chk("R8 lvl4 kept", v, 8'h08);
  endtask

  task automatic t_empty();
    logic [7:0] v;
    do_read(v);
    chk("R9 empty read", v, 8'h01);
    pulse(1);
    do_read(v);
    chk("R9 no stale clear", v, 8'h02);
    chk("R9 idle", rd_data_o, 8'h01);
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_priority();
    t_enable();
    t_capture();
    t_same_cycle();
    t_level();
    t_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule